// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Bit-Level Slave

This block behaves as a small serial EEPROM on a two-wire bus, modelled at the level of single bits. The clock line and the data line come in as plain levels, sampled on the system clock. The data line the slave drives goes out as a level, where 1 means released and 0 means pulled low. The block finds start and stop conditions and counts the clock pulses of a transfer. It decodes the transfer by that pulse count alone. The first byte is a command whose lowest bit picks read or write. On a write, the second byte sets the address. On a read, the slave shifts out the byte that its data register holds, most significant bit first.

The storage is an array of bytes. Reset fills it from a formula, and the bus never changes it. A write transfer only moves the address pointer, and the array location it selects is loaded into the data register as the address byte completes. A later read transfer returns that byte, so a controller sets the pointer with a write and then fetches the byte with a read. The address width is a parameter: 8 bits gives a 256-byte device, and 7 bits gives a 128-byte device that ignores the top address bit.

Top module: `eep_serial_slave`

## Requirements
- R1: Any data-line change seen while the clock line stays high is a bus condition, and it sets the pulse counter to 0 and releases the data output. A falling data line is a start and opens a transfer. A rising data line is a stop and closes the transfer.
- R2: With no transfer open (after reset, or after a stop), clock activity is ignored and the data output stays at 1.
- R3: Within an open transfer, a bit is sampled at each rising edge of the clock line where the data line keeps its value, and each sampled bit raises the pulse counter by one. The counter stops at 18, and clock pulses beyond that point change nothing.
- R4: A rising edge of the clock line that comes with a data-line change is discarded. No bit is taken and the counter does not move.
- R5: The first 8 sampled bits form the command, first bit most significant. Command bit 0 at 1 means read, and at 0 means write.
- R6: In a write transfer, sampled bits 10 to 17 form the address, first bit most significant. When bit 17 is sampled, the data register loads the array byte at the new address.
- R7: The slave pulls the data output to 0 from the falling clock edge after sampled bit 8 until the next falling edge. In a write transfer it does the same after sampled bit 17.
- R8: In a read transfer, from the falling edge after sampled bit 9, the slave presents the data register on the data output, most significant bit first, with one new bit per falling edge, for 8 bits. It then releases the line. The address is unchanged, and the same byte is reloaded when bit 17 is sampled.
- R9: After reset, array location a holds ((29*a) mod 256) XOR 0xA5. The address is 0, and the data register holds the byte of location 0.
- R10: Only the low ADDR_W address bits select a location. With ADDR_W = 7, address 0x85 reads location 0x05.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which both bus lines are sampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_o | output | 1 | Data line level driven by the slave (1 = released) |

## Verification
The bench builds two copies of the block on the same bus lines: one with ADDR_W = 8 (256 bytes) and one with ADDR_W = 7 (128 bytes). Setting an address with its top bit high shows the smaller copy wrapping to the lower half while the larger one does not. Each copy has its own per-clock reference model, and the bench checks the data output of both copies against their models. The stimulus covers an aborted transfer, a repeated start, a clock edge that comes with a data change, pulses past the counter limit, and idle clocking.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int TICK_W = 5;

  // pulse-count landmarks of a transfer
  localparam logic [TICK_W-1:0] TK_ACK_CMD    = TICK_W'(8);
  localparam logic [TICK_W-1:0] TK_BYTE2_LO   = TICK_W'(9);
  localparam logic [TICK_W-1:0] TK_BYTE2_HI   = TICK_W'(16);
  localparam logic [TICK_W-1:0] TK_ACK_ADDR   = TICK_W'(17);
  localparam logic [TICK_W-1:0] TK_SAT        = TICK_W'(18);

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic skew;
  } bus_ev_t;

  // power-up contents of one storage location
  function automatic logic [7:0] seed_byte(input int unsigned loc);
    int unsigned prod;
    prod = loc * 29;
    return prod[7:0] ^ 8'hA5;
  endfunction

  // level to drive after a falling clock edge at count tk
  function automatic logic drive_level(input logic [TICK_W-1:0] tk,
                                       input logic rd,
                                       input logic [7:0] dreg);
    if (tk == TK_ACK_CMD) return 1'b0;
    if (rd && tk == TK_BYTE2_LO) return dreg[7];
    if (rd && tk > TK_BYTE2_LO && tk <= TK_BYTE2_HI) return dreg[6];
    if (!rd && tk == TK_ACK_ADDR) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/eep_bus_monitor.sv
module eep_bus_monitor
  import eep_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev
);

  logic scl_q, sda_q;
  logic scl_up, sda_moved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_up    = ~scl_q & scl_i;
  assign sda_moved = sda_q ^ sda_i;

  always_comb begin
    ev.start = scl_q & scl_i & sda_q & ~sda_i;
    ev.stop  = scl_q & scl_i & ~sda_q & sda_i;
    ev.rise  = scl_up & ~sda_moved;
    ev.skew  = scl_up & sda_moved;
    ev.fall  = scl_q & ~scl_i;
  end

endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= seed_byte(i);
    end
  end

  assign rd_byte = cells[rd_addr];

endmodule

// File: rtl/eep_bit_engine.sv
module eep_bit_engine
  import eep_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev,
  input  logic              sda_bit,
  input  logic [7:0]        rd_byte,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              sda_o,
  output logic [TICK_W-1:0] tick_o,
  output logic              active_o,
  output logic              is_read_o,
  output logic              bit_taken_o,
  output logic              fetch_o,
  output logic              data_msb_o
);

  logic              active_q;
  logic [TICK_W-1:0] tick_q;
  logic [7:0]        cmd_q, addr_q, data_q, addr_n;
  logic              drive_q;
  logic              bus_cond, is_read, take, in_byte2, fetch;

  assign bus_cond = ev.start | ev.stop;
  assign is_read  = cmd_q[0];
  assign take     = active_q & ev.rise;
  assign in_byte2 = (tick_q >= TK_BYTE2_LO) && (tick_q <= TK_BYTE2_HI);
  assign addr_n   = (take && !is_read && in_byte2) ? {addr_q[6:0], sda_bit} : addr_q;
  assign fetch    = take && (tick_q == TK_BYTE2_HI);
  assign fetch_addr = addr_n[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tick_q   <= '0;
      cmd_q    <= '0;
      addr_q   <= '0;
      data_q   <= seed_byte(0);
      drive_q  <= 1'b1;
    end else if (bus_cond) begin
      active_q <= ev.start;
      tick_q   <= '0;
      drive_q  <= 1'b1;
    end else if (active_q) begin
      if (take) begin
        if (tick_q < TK_ACK_CMD) cmd_q <= {cmd_q[6:0], sda_bit};
        addr_q <= addr_n;
        if (fetch) data_q <= rd_byte;
        if (tick_q < TK_SAT) tick_q <= tick_q + TICK_W'(1);
      end else if (ev.fall) begin
        drive_q <= drive_level(tick_q, is_read, data_q);
        if (is_read && tick_q > TK_BYTE2_LO && tick_q <= TK_BYTE2_HI)
          data_q <= {data_q[6:0], 1'b0};
      end
    end
  end

  assign sda_o       = drive_q;
  assign tick_o      = tick_q;
  assign active_o    = active_q;
  assign is_read_o   = is_read;
  assign bit_taken_o = take;
  assign fetch_o     = fetch;
  assign data_msb_o  = data_q[7];

endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o
);

  bus_ev_t           ev;
  logic [ADDR_W-1:0] fetch_addr;
  logic [7:0]        rd_byte;
  logic [TICK_W-1:0] tick;
  logic              active, is_read, bit_taken, fetch_now, data_msb;

  eep_bus_monitor u_mon (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev    (ev)
  );

  eep_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (fetch_addr),
    .rd_byte (rd_byte)
  );

  eep_bit_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev          (ev),
    .sda_bit     (sda_i),
    .rd_byte     (rd_byte),
    .fetch_addr  (fetch_addr),
    .sda_o       (sda_o),
    .tick_o      (tick),
    .active_o    (active),
    .is_read_o   (is_read),
    .bit_taken_o (bit_taken),
    .fetch_o     (fetch_now),
    .data_msb_o  (data_msb)
  );

endmodule

// File: rtl/eep_serial_slave_chk.sv
module eep_serial_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_o,
  input logic [4:0] tick,
  input logic       active,
  input logic       is_read,
  input logic       bit_taken,
  input logic       fetch_now,
  input logic       data_msb
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sda_o); // R2

  AST_COND_CLEARS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_i) && scl_i && ($past(sda_i) != sda_i)) |=> (tick == 5'd0)); // R1

  AST_SKEW_NOT_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_i) && scl_i && ($past(sda_i) != sda_i)) |=> $stable(tick)); // R4

  AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_taken && tick < 5'd18) |=> (tick == $past(tick) + 5'd1)); // R3

  AST_ACK_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_i) && active && tick == 5'd8) |=> !sda_o); // R7

  AST_READ_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_i) && active && is_read && tick == 5'd9) |=> (sda_o == $past(data_msb))); // R8

  AST_FETCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_now |=> (tick == 5'd17)); // R6

endmodule

bind eep_serial_slave eep_serial_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_i     (sda_i),
  .sda_o     (sda_o),
  .tick      (tick),
  .active    (active),
  .is_read   (is_read),
  .bit_taken (bit_taken),
  .fetch_now (fetch_now),
  .data_msb  (data_msb)
);

// File: tb/eep_serial_slave_test.sv
module eep_serial_slave_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic so_big, so_small;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  eep_serial_slave #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_o(so_big));

  eep_serial_slave #(.ADDR_W(7)) uut_small (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_o(so_small));

  // expected contents: (29*a mod 256) xor 0xA5, restated as a sum of shifts
  function automatic int ref_byte(int a);
    return ((a * 16 + a * 8 + a * 4 + a) % 256) ^ 165;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference, one per instance ----------------
  int m_tick [2];
  int m_cmd  [2];
  int m_addr [2];
  int m_dat  [2];
  int m_act  [2];
  int m_exp  [2];
  int p_scl = 1;
  int p_sda = 1;

  task automatic model_step(int i, int mask);
    int b, rd;
    b = sda;
    if (p_scl == 1 && scl == 1 && sda != p_sda) begin
      m_tick[i] = 0;
      m_act[i]  = (sda == 0) ? 1 : 0;
      m_exp[i]  = 1;
    end else if (m_act[i] == 1) begin
      rd = m_cmd[i] % 2;
      if (p_scl == 0 && scl == 1 && sda == p_sda) begin
        if (m_tick[i] < 8) m_cmd[i] = (m_cmd[i] * 2 + b) % 256;
        else if (m_tick[i] >= 9 && m_tick[i] <= 16 && rd == 0)
          m_addr[i] = (m_addr[i] * 2 + b) % 256;
        if (m_tick[i] == 16) m_dat[i] = ref_byte(m_addr[i] % mask);
        if (m_tick[i] < 18) m_tick[i]++;
      end else if (p_scl == 1 && scl == 0) begin
        if (m_tick[i] == 8) m_exp[i] = 0;
        else if (rd == 1 && m_tick[i] == 9) m_exp[i] = (m_dat[i] / 128) % 2;
        else if (rd == 1 && m_tick[i] >= 10 && m_tick[i] <= 16) begin
          m_exp[i] = (m_dat[i] / 64) % 2;
          m_dat[i] = (m_dat[i] * 2) % 256;
        end else if (rd == 0 && m_tick[i] == 17) m_exp[i] = 0;
        else m_exp[i] = 1;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_tick[i] = 0; m_cmd[i] = 0; m_addr[i] = 0;
        m_dat[i] = ref_byte(0); m_act[i] = 0; m_exp[i] = 1;
      end
      p_scl = 1; p_sda = 1;
      cmp_on = 1'b1;
    end else begin
      model_step(0, 256);
      model_step(1, 128);
      p_scl = scl;
      p_sda = sda;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      check("R1/R2/R7/R8 per-clock sda_o uut", so_big, m_exp[0]);
      check("R1/R2/R7/R8 per-clock sda_o uut_small", so_small, m_exp[1]);
    end
  end

  // ---------------- bus driver tasks ----------------
  task automatic set_lines(input logic s, input logic d);
    @(negedge clk);
    scl = s;
    sda = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, output logic o0, output logic o1);
    set_lines(1'b0, b);
    set_lines(1'b1, b);
    o0 = so_big;
    o1 = so_small;
  endtask

  task automatic bus_start();
    set_lines(1'b0, 1'b1);
    set_lines(1'b1, 1'b1);
    set_lines(1'b1, 1'b0);
  endtask

  task automatic bus_stop();
    set_lines(1'b0, 1'b0);
    set_lines(1'b1, 1'b0);
    set_lines(1'b1, 1'b1);
  endtask

  task automatic send_byte(input int v, output logic a0, output logic a1);
    logic x, y;
    for (int k = 7; k >= 0; k--) clock_bit(1'((v >> k) & 1), x, y);
    clock_bit(1'b1, a0, a1);
  endtask

  task automatic set_pointer(input int a);
    logic a0, a1;
    bus_start();
    send_byte(8'hA0, a0, a1);
    check("R7 ack after write command", {a0, a1}, 0);
    send_byte(a, a0, a1);
    check("R6/R7 ack after address byte", {a0, a1}, 0);
    bus_stop();
  endtask

  task automatic read_cur(input int e0, input int e1, input string tag);
    logic a0, a1, r0, r1;
    int v0, v1;
    bus_start();
    send_byte(8'hA1, a0, a1);
    check("R5/R7 ack after read command", {a0, a1}, 0);
    v0 = 0; v1 = 0;
    for (int k = 0; k < 8; k++) begin
      clock_bit(1'b1, r0, r1);
      v0 = v0 * 2 + int'(r0);
      v1 = v1 * 2 + int'(r1);
    end
    check({tag, " uut"}, v0, e0);
    check({tag, " uut_small"}, v1, e1);
    clock_bit(1'b1, r0, r1);
    check("R8 line released after read byte", {r0, r1}, 3);
    bus_stop();
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic o0, o1;
    repeat (4) @(negedge clk);
    check("R9 reset released uut", so_big, 1);
    check("R2 reset released uut_small", so_small, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // read with no pointer set: location 0 from reset
    read_cur(ref_byte(0), ref_byte(0), "R9/R8 read of reset byte");
    read_cur(ref_byte(0), ref_byte(0), "R8 reload on repeated read");

    set_pointer(8'h13);
    read_cur(ref_byte(8'h13), ref_byte(8'h13), "R6/R8 read at 0x13");

    // top address bit: small copy wraps
    set_pointer(8'h85);
    read_cur(ref_byte(8'h85), ref_byte(8'h05), "R10 read at 0x85");

    // idle clocking without a start
    for (int k = 0; k < 6; k++) begin
      clock_bit(1'(k % 2), o0, o1);
      check("R2 idle clock ignored", {o0, o1}, 3);
    end
    read_cur(ref_byte(8'h85), ref_byte(8'h05), "R2 pointer kept over idle");

    // aborted transfer then a fresh one
    bus_start();
    clock_bit(1'b1, o0, o1); clock_bit(1'b0, o0, o1);
    clock_bit(1'b1, o0, o1); clock_bit(1'b0, o0, o1);
    bus_stop();
    check("R1 released after stop", {so_big, so_small}, 3);
    set_pointer(8'h2A);
    read_cur(ref_byte(8'h2A), ref_byte(8'h2A), "R1 read after abort");

    // repeated start mid-command
    bus_start();
    for (int k = 0; k < 5; k++) clock_bit(1'(k % 2), o0, o1);
    set_pointer(8'h31);
    read_cur(ref_byte(8'h31), ref_byte(8'h31), "R1 read after repeated start");

    // clock rise with a data change is not a bit
    bus_start();
    clock_bit(1'b1, o0, o1); clock_bit(1'b0, o0, o1); clock_bit(1'b1, o0, o1);
    set_lines(1'b0, 1'b0);
    set_lines(1'b1, 1'b1);
    for (int k = 0; k < 5; k++) clock_bit(1'b0, o0, o1);
    clock_bit(1'b1, o0, o1);
    check("R4 ack after 8 clean bits", {o0, o1}, 0);
    send_byte(8'h07, o0, o1);
    check("R4 ack after address", {o0, o1}, 0);
    bus_stop();
    read_cur(ref_byte(8'h07), ref_byte(8'h07), "R4 read at 0x07");

    // pulses beyond the counter limit
    bus_start();
    send_byte(8'hA0, o0, o1);
    send_byte(8'h44, o0, o1);
    for (int k = 0; k < 4; k++) begin
      clock_bit(1'b0, o0, o1);
      check("R3 no drive past limit", {o0, o1}, 3);
    end
    bus_stop();
    read_cur(ref_byte(8'h44), ref_byte(8'h44), "R3/R5 read at 0x44");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule